// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Packet FIFO

This block is the transmit buffer of one USB device endpoint. On the CPU side, software pushes packet bytes one write at a time and then commits the packet. On the USB side, a protocol engine announces each IN token with a one-cycle request. The block answers on the next cycle with the length of the oldest committed packet, or with a NAK when it has nothing to send. The engine then pulls the bytes in order and ends the transfer with either an acknowledged-done pulse or a failed-done pulse.

A configuration bit sets the capacity to one or two committed packets of up to 64 bytes each. A separate length register records the size of each committed packet. The block drives the ready, present and interrupt flags. It can commit a packet automatically once a programmed maximum size has been written. It handles zero-length packets, both when software commits one and when the engine needs one in isochronous mode. The flush, interrupt-clear and configuration inputs are level or pulse controls from a register file. The configuration inputs are changed only while no packet is committed and no transfer is running.

Top module: `in_pkt_fifo`

## Requirements
- R1: With `cfg_dbl`=1 up to two committed packets are held; with `cfg_dbl`=0 only one is held. A commit or byte write made while every buffer holds a committed packet is ignored.
- R2: Each `cpu_wr_valid` cycle appends `cpu_wr_data` to the packet being loaded. During a transfer, `usb_data` shows the byte at the read position, starting at byte 0, and each `usb_rd` pulse advances it by one.
- R3: `pkt_ready` is 1 exactly when every available buffer holds a committed packet. In double mode, a commit that leaves the other buffer free therefore reads back as `pkt_ready`=0 on the next cycle.
- R4: A commit never sets `irq_in`. An acknowledged done (`usb_done_ack`) of a committed packet sets `irq_in`. A `cpu_irq_clr` pulse clears it, and a same-cycle set wins.
- R5: `pkt_present` is 1 while at least one committed packet is waiting.
- R6: A commit with no bytes written since the previous commit queues a packet whose response has `usb_resp_nak`=0 and `usb_resp_len`=0.
- R7: With `cfg_autoset`=1 and a nonzero `cfg_maxpkt`, the write that brings the loading count to `cfg_maxpkt` commits the packet without `cpu_commit`.
- R8: With `cfg_iso`=1, a request with no committed packet gets a zero-length response (`usb_resp_nak`=0, `usb_resp_len`=0). Its done pulse releases no buffer and sets no interrupt.
- R9: With `cfg_iso`=0, a request with no committed packet gets `usb_resp_nak`=1 and `usb_resp_len`=0, and the state is unchanged.
- R10: `usb_done_fail` ends a transfer but keeps the packet. The next request returns the same length and restarts the data at byte 0.
- R11: A `cpu_flush` pulse, given outside a transfer, discards the oldest committed packet and sets `irq_in`.
- R12: A `usb_stall` pulse sets `irq_in`.
- R13: `usb_resp_valid` pulses in the cycle after an accepted `usb_req`. After an acknowledged done, the freed buffer shows in `pkt_present` and `pkt_ready` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dbl | input | 1 | 1 = two packet buffers, 0 = one |
| cfg_iso | input | 1 | 1 = isochronous endpoint |
| cfg_autoset | input | 1 | Enable automatic commit at maximum size |
| cfg_maxpkt | input | 7 | Maximum packet size for automatic commit (0 disables) |
| cpu_wr_valid | input | 1 | Write one data byte |
| cpu_wr_data | input | 8 | Data byte |
| cpu_commit | input | 1 | Commit the loaded packet (pulse) |
| cpu_flush | input | 1 | Discard the oldest committed packet (pulse) |
| cpu_irq_clr | input | 1 | Clear the interrupt flag (pulse) |
| pkt_ready | output | 1 | All buffers hold committed packets |
| pkt_present | output | 1 | At least one committed packet waits |
| irq_in | output | 1 | IN endpoint interrupt flag |
| usb_req | input | 1 | Host IN token seen (pulse) |
| usb_rd | input | 1 | Advance to the next data byte |
| usb_done_ack | input | 1 | Transfer finished and acknowledged |
| usb_done_fail | input | 1 | Transfer timed out; keep packet |
| usb_stall | input | 1 | Stall condition raised by the engine |
| usb_resp_valid | output | 1 | Response to a request is valid (pulse) |
| usb_resp_nak | output | 1 | Response is a NAK |
| usb_resp_len | output | 7 | Length of the packet being sent |
| usb_data | output | 8 | Byte at the current read position |

## Verification
The hardest situation to reach is a failed transfer that has already pulled part of a packet while a second packet waits behind it. A later retry must replay the first packet from byte 0, not skip ahead to the second one. The bench loads a packet, reads part of it and signals a failed done. It then issues a new request and checks the length and the first byte again. In a separate test it stacks two packets and flushes, to show that the older one goes and the younger one is served.

// File: rtl/in_pkt_fifo.sv
module in_pkt_fifo #(
  parameter int DW        = 8,
  parameter int BUF_BYTES = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_dbl,
  input  logic                              cfg_iso,
  input  logic                              cfg_autoset,
  input  logic [$clog2(BUF_BYTES+1)-1:0]    cfg_maxpkt,
  input  logic                              cpu_wr_valid,
  input  logic [DW-1:0]                     cpu_wr_data,
  input  logic                              cpu_commit,
  input  logic                              cpu_flush,
  input  logic                              cpu_irq_clr,
  output logic                              pkt_ready,
  output logic                              pkt_present,
  output logic                              irq_in,
  input  logic                              usb_req,
  input  logic                              usb_rd,
  input  logic                              usb_done_ack,
  input  logic                              usb_done_fail,
  input  logic                              usb_stall,
  output logic                              usb_resp_valid,
  output logic                              usb_resp_nak,
  output logic [$clog2(BUF_BYTES+1)-1:0]    usb_resp_len,
  output logic [DW-1:0]                     usb_data
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = $clog2(BUF_BYTES+1);

  logic [DW-1:0] mem [2][BUF_BYTES];
  logic [CW-1:0] len_q [2];
  logic [CW-1:0] wr_cnt, rd_ptr;
  logic [1:0]    cnt;
  logic          head, busy, zlp_fb;

  logic [1:0]    cap;
  logic          tail, space, wr_ok, auto_commit, commit_ok;
  logic          flush_ok, release_ok;
  logic [CW-1:0] wr_cnt_inc, commit_len;

  assign cap        = cfg_dbl ? 2'd2 : 2'd1;
  assign tail       = head ^ cnt[0];
  assign space      = cnt < cap;
  assign wr_cnt_inc = wr_cnt + CW'(1);
  assign wr_ok      = cpu_wr_valid && space && (wr_cnt < CW'(BUF_BYTES));
  assign auto_commit = wr_ok && cfg_autoset && (cfg_maxpkt != '0) && (wr_cnt_inc == cfg_maxpkt);
  assign commit_ok  = (cpu_commit || auto_commit) && space;
  assign commit_len = wr_ok ? wr_cnt_inc : wr_cnt;
  assign flush_ok   = cpu_flush && !busy && (cnt != 2'd0);
  assign release_ok = (usb_done_ack && busy && !zlp_fb) || flush_ok;

  assign pkt_ready   = cnt >= cap;
  assign pkt_present = cnt != 2'd0;
  assign usb_data    = mem[head][rd_ptr[AW-1:0]];

  always_ff @(posedge clk)
    if (wr_ok) mem[tail][wr_cnt[AW-1:0]] <= cpu_wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else if (commit_ok) begin
      len_q[tail] <= commit_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      cnt    <= 2'd0;
      head   <= 1'b0;
    end else begin
      if (commit_ok)   wr_cnt <= '0;
      else if (wr_ok)  wr_cnt <= wr_cnt_inc;
      cnt <= cnt + {1'b0, commit_ok} - {1'b0, release_ok};
      if (release_ok) head <= ~head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      zlp_fb         <= 1'b0;
      rd_ptr         <= '0;
      usb_resp_valid <= 1'b0;
      usb_resp_nak   <= 1'b0;
      usb_resp_len   <= '0;
    end else begin
      usb_resp_valid <= 1'b0;
      if (busy) begin
        if (usb_done_ack || usb_done_fail) begin
          busy   <= 1'b0;
          zlp_fb <= 1'b0;
          rd_ptr <= '0;
        end else if (usb_rd && rd_ptr < len_q[head]) begin
          rd_ptr <= rd_ptr + CW'(1);
        end
      end else if (usb_req) begin
        usb_resp_valid <= 1'b1;
        rd_ptr         <= '0;
        if (cnt != 2'd0) begin
          busy         <= 1'b1;
          usb_resp_nak <= 1'b0;
          usb_resp_len <= len_q[head];
        end else if (cfg_iso) begin
          busy         <= 1'b1;
          zlp_fb       <= 1'b1;
          usb_resp_nak <= 1'b0;
          usb_resp_len <= '0;
        end else begin
          usb_resp_nak <= 1'b1;
          usb_resp_len <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_in <= 1'b0;
    else if ((usb_done_ack && busy && !zlp_fb) || flush_ok || cpu_flush || usb_stall)
      irq_in <= 1'b1;
    else if (cpu_irq_clr)
      irq_in <= 1'b0;
  end
endmodule

// File: rtl/in_pkt_fifo_chk.sv
module in_pkt_fifo_chk #(
  parameter int CW        = 7,
  parameter int BUF_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_iso,
  input logic          cpu_commit,
  input logic          cpu_flush,
  input logic          usb_done_ack,
  input logic          usb_stall,
  input logic          pkt_present,
  input logic          irq_in,
  input logic          usb_resp_valid,
  input logic          usb_resp_nak,
  input logic [CW-1:0] usb_resp_len
);
  AST_COMMIT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_commit && !irq_in && !usb_done_ack && !cpu_flush && !usb_stall |=> !irq_in); // R4
  AST_RELEASE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pkt_present) |-> irq_in); // R11
  AST_NAK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    usb_resp_valid && usb_resp_nak |-> $past(!pkt_present) && $past(!cfg_iso)); // R9
  AST_ISO_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    usb_resp_valid && $past(cfg_iso) |-> !usb_resp_nak); // R8
  AST_NAK_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    usb_resp_valid && usb_resp_nak |-> usb_resp_len == '0); // R9
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    usb_resp_valid |-> usb_resp_len <= CW'(BUF_BYTES)); // R1
  AST_STALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    usb_stall |=> irq_in); // R12
  AST_FLUSH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_flush |=> irq_in); // R11
endmodule

bind in_pkt_fifo in_pkt_fifo_chk #(.CW(CW), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cpu_commit(cpu_commit),
  .cpu_flush(cpu_flush), .usb_done_ack(usb_done_ack), .usb_stall(usb_stall),
  .pkt_present(pkt_present), .irq_in(irq_in), .usb_resp_valid(usb_resp_valid),
  .usb_resp_nak(usb_resp_nak), .usb_resp_len(usb_resp_len)
);

// File: tb/in_pkt_fifo_test.sv
module in_pkt_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dbl = 1'b0, cfg_iso = 1'b0, cfg_autoset = 1'b0;
  logic [6:0] cfg_maxpkt = 7'd0;
  logic cpu_wr_valid = 1'b0, cpu_commit = 1'b0, cpu_flush = 1'b0, cpu_irq_clr = 1'b0;
  logic [7:0] cpu_wr_data = 8'd0;
  logic usb_req = 1'b0, usb_rd = 1'b0, usb_done_ack = 1'b0, usb_done_fail = 1'b0, usb_stall = 1'b0;
  logic pkt_ready, pkt_present, irq_in, usb_resp_valid, usb_resp_nak;
  logic [6:0] usb_resp_len;
  logic [7:0] usb_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  in_pkt_fifo uut (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .cfg_iso(cfg_iso),
    .cfg_autoset(cfg_autoset), .cfg_maxpkt(cfg_maxpkt),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_data(cpu_wr_data),
    .cpu_commit(cpu_commit), .cpu_flush(cpu_flush), .cpu_irq_clr(cpu_irq_clr),
    .pkt_ready(pkt_ready), .pkt_present(pkt_present), .irq_in(irq_in),
    .usb_req(usb_req), .usb_rd(usb_rd), .usb_done_ack(usb_done_ack),
    .usb_done_fail(usb_done_fail), .usb_stall(usb_stall),
    .usb_resp_valid(usb_resp_valid), .usb_resp_nak(usb_resp_nak),
    .usb_resp_len(usb_resp_len), .usb_data(usb_data)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic wr_bytes(int n, int base);
    for (int i = 0; i < n; i++) begin
      cpu_wr_valid = 1'b1; cpu_wr_data = 8'(base + i);
      tick();
    end
    cpu_wr_valid = 1'b0;
  endtask

  task automatic commit;
    cpu_commit = 1'b1; tick(); cpu_commit = 1'b0;
  endtask

  task automatic irq_clear;
    cpu_irq_clr = 1'b1; tick(); cpu_irq_clr = 1'b0;
  endtask

  task automatic host_req(int nak, int len, string tag);
    usb_req = 1'b1; tick(); usb_req = 1'b0;
    check({tag, " resp_valid"}, usb_resp_valid, 1);
    check({tag, " resp_nak"}, usb_resp_nak, nak);
    check({tag, " resp_len"}, usb_resp_len, len);
  endtask

  task automatic read_bytes(int n, int base, string tag);
    for (int i = 0; i < n; i++) begin
      check({tag, " data"}, usb_data, (base + i) & 255);
      usb_rd = 1'b1; tick(); usb_rd = 1'b0;
    end
  endtask

  task automatic ack;
    usb_done_ack = 1'b1; tick(); usb_done_ack = 1'b0;
  endtask

  task automatic t_reset;
    check("R5 reset present", pkt_present, 0);
    check("R3 reset ready", pkt_ready, 0);
    check("R4 reset irq", irq_in, 0);
    check("R13 reset resp_valid", usb_resp_valid, 0);
  endtask

  task automatic t_single;
    cfg_dbl = 1'b0;
    wr_bytes(3, 8'h40);
    commit();
    check("R3 single ready", pkt_ready, 1);
    check("R5 single present", pkt_present, 1);
    check("R4 commit no irq", irq_in, 0);
    wr_bytes(1, 8'hEE);
    commit();
    host_req(0, 3, "R1 single ignored extra");
    read_bytes(3, 8'h40, "R2 single");
    ack();
    check("R13 ack present", pkt_present, 0);
    check("R13 ack ready", pkt_ready, 0);
    check("R4 ack irq", irq_in, 1);
    irq_clear();
    check("R4 irq cleared", irq_in, 0);
  endtask

  task automatic t_double;
    cfg_dbl = 1'b1;
    wr_bytes(2, 8'h10);
    commit();
    check("R3 dbl first ready", pkt_ready, 0);
    check("R5 dbl first present", pkt_present, 1);
    wr_bytes(4, 8'h20);
    commit();
    check("R1 dbl two ready", pkt_ready, 1);
    host_req(0, 2, "R1 dbl pkt0");
    read_bytes(2, 8'h10, "R2 dbl pkt0");
    ack();
    check("R13 dbl ready after ack", pkt_ready, 0);
    check("R5 dbl present after ack", pkt_present, 1);
    check("R4 dbl irq", irq_in, 1);
    irq_clear();
    host_req(0, 4, "R1 dbl pkt1");
    read_bytes(4, 8'h20, "R2 dbl pkt1");
    ack();
    check("R5 dbl empty", pkt_present, 0);
    irq_clear();
  endtask

  task automatic t_zlp;
    commit();
    check("R6 zlp present", pkt_present, 1);
    host_req(0, 0, "R6 zlp");
    ack();
    check("R6 zlp released", pkt_present, 0);
    check("R4 zlp irq", irq_in, 1);
    irq_clear();
  endtask

  task automatic t_autoset;
    cfg_autoset = 1'b1; cfg_maxpkt = 7'd5;
    wr_bytes(4, 8'h60);
    check("R7 not yet", pkt_present, 0);
    wr_bytes(1, 8'h64);
    check("R7 autoset present", pkt_present, 1);
    check("R4 autoset no irq", irq_in, 0);
    cfg_autoset = 1'b0;
    host_req(0, 5, "R7 autoset");
    read_bytes(5, 8'h60, "R7 autoset");
    ack();
    irq_clear();
  endtask

  task automatic t_nak;
    cfg_iso = 1'b0;
    host_req(1, 0, "R9 bulk nak");
    check("R9 nak present", pkt_present, 0);
    check("R9 nak irq", irq_in, 0);
  endtask

  task automatic t_iso;
    cfg_iso = 1'b1;
    host_req(0, 0, "R8 iso zlp");
    ack();
    check("R8 iso irq", irq_in, 0);
    check("R8 iso present", pkt_present, 0);
    cfg_iso = 1'b0;
  endtask

  task automatic t_retry;
    wr_bytes(3, 8'h70);
    commit();
    wr_bytes(2, 8'h90);
    commit();
    host_req(0, 3, "R10 first try");
    read_bytes(2, 8'h70, "R10 partial");
    usb_done_fail = 1'b1; tick(); usb_done_fail = 1'b0;
    check("R10 kept present", pkt_present, 1);
    check("R10 kept ready", pkt_ready, 1);
    check("R10 no irq", irq_in, 0);
    host_req(0, 3, "R10 retry");
    read_bytes(3, 8'h70, "R10 replay");
    ack();
    irq_clear();
    host_req(0, 2, "R10 second pkt");
    read_bytes(2, 8'h90, "R10 second pkt");
    ack();
    irq_clear();
  endtask

  task automatic t_flush;
    wr_bytes(1, 8'hA0);
    commit();
    wr_bytes(2, 8'hB0);
    commit();
    cpu_flush = 1'b1; tick(); cpu_flush = 1'b0;
    check("R11 flush irq", irq_in, 1);
    check("R11 flush present", pkt_present, 1);
    check("R11 flush ready", pkt_ready, 0);
    irq_clear();
    host_req(0, 2, "R11 survivor");
    read_bytes(2, 8'hB0, "R11 survivor");
    ack();
    irq_clear();
  endtask

  task automatic t_stall;
    usb_stall = 1'b1; tick(); usb_stall = 1'b0;
    check("R12 stall irq", irq_in, 1);
    irq_clear();
    check("R12 stall cleared", irq_in, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_double();
    t_zlp();
    t_autoset();
    t_nak();
    t_iso();
    t_retry();
    t_flush();
    t_stall();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule